// File: doc/BRIEF.md
# Cascadable Serial Configuration Port

This block is the serial slave that loads a crosspoint router's routing registers. An external master lowers chip select, then clocks in configuration words most significant bit first. Data is captured on the rising serial clock edge, with the clock idling low. When chip select returns high, the block decodes the final 16 bits of the frame into an output address, a four-bit data field and an update-all flag. It then presents them with a one-cycle load pulse to the routing register bank.

Each captured bit is also passed on through a serial output that changes on falling clock edges. Several ports can therefore be cascaded, each data output feeding the next data input, with chip select and clock shared. N ports then take 16·N clocks per frame. The serial output is always driven and holds its last value between frames. A session opens only while the three parallel-side strobes (write, enable, update) are all inactive high. All pins are asynchronous to the system clock and are synchronised before use. The system clock must run at least eight times faster than the serial clock.

Top module: `scp_serial_port`

## Requirements
- R1: A configuration word is 16 bits and is received most significant bit first: the first of the last 16 captured bits lands in cfg_word[15].
- R2: sdi is captured only on rising sclk edges that occur while a session is open; sclk edges outside a session shift nothing.
- R3: sdo changes only on falling sclk edges inside a session. The bit captured on rising edge k appears on sdo after the falling edge that follows rising edge k+15, so a downstream port captures it on edge k+16. The shift chain holds zeros after reset.
- R4: While cs_n is high, sdo holds its last value and stays driven, whatever sclk does.
- R5: A session opens only when cs_n falls while par_wr_n, par_ce_n and par_upd_n are all high. A frame that starts otherwise causes no capture and no load.
- R6: When cs_n rises to close a session that saw at least 16 rising sclk edges, cfg_load pulses high for exactly one clock, with cfg_word equal to the last 16 bits captured (frames longer than 16 keep the most recent 16).
- R7: A session closed after fewer than 16 rising sclk edges produces no load pulse.
- R8: Field decode at load: cfg_addr = word[5:4] selects the output, cfg_data = word[3:0] with cfg_data[3] = 1 meaning disable that output, and cfg_upd_all = word[6] requests that all switch registers update at once.
- R9: After reset, sdo, cfg_load, cfg_word and the decoded fields are all 0.
- R10: Two ports cascaded sdo to sdi with shared cs_n and sclk load, after a 32-clock frame, the second-sent word into the first port and the first-sent word into the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idle low, asynchronous |
| sdi | input | 1 | Serial data in |
| par_wr_n | input | 1 | Parallel write strobe; must be high for serial mode |
| par_ce_n | input | 1 | Parallel chip enable; must be high for serial mode |
| par_upd_n | input | 1 | Parallel update strobe; must be high for serial mode |
| sdo | output | 1 | Serial data out for cascading, always driven |
| cfg_load | output | 1 | One-cycle load strobe to the routing register bank |
| cfg_word | output | 16 | Captured configuration word |
| cfg_addr | output | 2 | Output address field |
| cfg_data | output | 4 | Input select / disable field |
| cfg_upd_all | output | 1 | Update-all request |

## Verification
Exact 16-clock words with assorted bit patterns show the bit order and the field decode. A 24-clock frame shows that only the most recent 16 bits are kept, and a 10-clock frame shows that short frames are dropped. A 16-clock frame split into two bytes with a long pause shows that a gap in the clock does not end the word. A frame opened while a parallel strobe is low, and clock toggling while deselected, show the gating and the hold of sdo. The echoed stream is checked bit by bit against the 16-edge delay on every clock. A two-port cascade with a 32-clock frame separates the 16-clock delay from an off-by-one of either sign.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_LSB = 4;
  localparam int ADDR_W   = 2;
  localparam int DATA_LSB = 0;
  localparam int DATA_W   = 4;
  localparam int UPD_BIT  = 6;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              upd_all;
  } cfg_fields_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/scp_shift_engine.sv
module scp_shift_engine #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              mode_ok_s,
  output logic              sdo,
  output logic              frame_done,
  output logic [WORD_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic              sclk_q, cs_n_q;
  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sdo_q, sdo_d;
  logic              done_q, done_d;
  logic              rise, fall, cs_fall, cs_rise, open_evt;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign cs_fall  = ~cs_n_s & cs_n_q;
  assign cs_rise  = cs_n_s & ~cs_n_q;
  assign open_evt = cs_fall & mode_ok_s;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    sdo_d    = sdo_q;
    done_d   = 1'b0;
    if (open_evt) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (cs_rise) begin
      active_d = 1'b0;
      done_d   = active_q && (cnt_q == CNT_FULL);
    end
    if (active_q && rise) begin
      sr_d = {sr_q[WORD_W-2:0], sdi_s};
      if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
    end
    if (active_q && fall) sdo_d = sr_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      sdo_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      cs_n_q   <= cs_n_s;
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sr_q     <= sr_d;
      sdo_q    <= sdo_d;
      done_q   <= done_d;
    end
  end

  assign sdo        = sdo_q;
  assign frame_done = done_q;
  assign frame_word = sr_q;

  // R5: a session only opens after a select edge seen with all strobes high
  a_r5_open_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(mode_ok_s));
  // R3/R4: sdo moves only after an in-session falling edge
  a_r3_sdo_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_q && fall) |=> $stable(sdo_q));
  // R2: capture only inside a session
  a_r2_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> $stable(sr_q));
  // R7: edge counter never runs past a full word
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R6: completion only follows an open session
  a_r6_done_after_session: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(active_q) && !active_q));
endmodule

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] frame_word,
  output logic              cfg_load,
  output logic [WORD_W-1:0] cfg_word,
  output cfg_fields_t       cfg_fields
);
  logic              load_q;
  logic [WORD_W-1:0] word_q, word_d;
  cfg_fields_t       fld_q, fld_d;

  always_comb begin
    word_d = word_q;
    fld_d  = fld_q;
    if (frame_done) begin
      word_d        = frame_word;
      fld_d.addr    = frame_word[ADDR_LSB +: ADDR_W];
      fld_d.data    = frame_word[DATA_LSB +: DATA_W];
      fld_d.upd_all = frame_word[UPD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      word_q <= '0;
      fld_q  <= '0;
    end else begin
      load_q <= frame_done;
      word_q <= word_d;
      fld_q  <= fld_d;
    end
  end

  assign cfg_load   = load_q;
  assign cfg_word   = word_q;
  assign cfg_fields = fld_q;

  // R6: the load strobe lasts one cycle
  a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !cfg_load);
  // R8: fields stay put between loads
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(fld_q) && $stable(word_q)));
endmodule

// File: rtl/scp_serial_port.sv
module scp_serial_port
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              par_wr_n,
  input  logic              par_ce_n,
  input  logic              par_upd_n,
  output logic              sdo,
  output logic              cfg_load,
  output logic [WORD_W-1:0] cfg_word,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_upd_all
);
  localparam int PIN_W = 6;
  localparam logic [PIN_W-1:0] PIN_RST = 6'b111100; // upd,ce,wr,cs high; sclk,sdi low

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             frame_done;
  logic [WORD_W-1:0] frame_word;
  cfg_fields_t      fields;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign pins_raw = {par_upd_n, par_ce_n, par_wr_n, cs_n, sclk, sdi};

  scp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .din  (pins_raw),
    .dout (pins_s)
  );

  scp_shift_engine #(.WORD_W(WORD_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_n_s    (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .mode_ok_s (&pins_s[5:3]),
    .sdo       (sdo),
    .frame_done(frame_done),
    .frame_word(frame_word)
  );

  scp_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .frame_done(frame_done),
    .frame_word(frame_word),
    .cfg_load  (cfg_load),
    .cfg_word  (cfg_word),
    .cfg_fields(fields)
  );

  assign cfg_addr    = fields.addr;
  assign cfg_data    = fields.data;
  assign cfg_upd_all = fields.upd_all;
endmodule

// File: tb/scp_serial_port_tb.sv
module scp_serial_port_tb;
  localparam time TCLK = 5ns;
  localparam time H    = 40ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic par_wr_n = 1'b1, par_ce_n = 1'b1, par_upd_n = 1'b1;
  logic sdo, sdo_b, load, load_b, upd, upd_b;
  logic [15:0] word, word_b;
  logic [1:0] addr, addr_b;
  logic [3:0] data, data_b;

  int checks = 0, errors = 0;
  bit stream[$];
  logic [15:0] exp_a[$], exp_b[$];
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  scp_serial_port u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .par_wr_n(par_wr_n), .par_ce_n(par_ce_n), .par_upd_n(par_upd_n), .sdo(sdo),
    .cfg_load(load), .cfg_word(word), .cfg_addr(addr), .cfg_data(data), .cfg_upd_all(upd));

  // R10: second port fed from the first
  scp_serial_port u_dut_tail (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdo),
    .par_wr_n(par_wr_n), .par_ce_n(par_ce_n), .par_upd_n(par_upd_n), .sdo(sdo_b),
    .cfg_load(load_b), .cfg_word(word_b), .cfg_addr(addr_b), .cfg_data(data_b), .cfg_upd_all(upd_b));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each load strobe
  always @(negedge clk) begin
    if (!done && load) begin
      if (exp_a.size() == 0) check(0, "R7 unexpected load", {16'h0, word}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_a.pop_front();
        check(word == e, "R6/R1 word", {16'h0, word}, {16'h0, e});
        check({upd, addr, data} == {e[6], e[5:4], e[3:0]}, "R8 fields",
              {25'h0, upd, addr, data}, {25'h0, e[6], e[5:4], e[3:0]});
      end
    end
    if (!done && load_b) begin
      if (exp_b.size() == 0) check(0, "R7 unexpected tail load", {16'h0, word_b}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_b.pop_front();
        check(word_b == e, "R10 cascade word", {16'h0, word_b}, {16'h0, e});
      end
    end
  end

  function automatic bit sbit(input int idx);
    return (idx >= 0) ? stream[idx] : 1'b0;
  endfunction

  task automatic send_frame(input logic [63:0] bits, input int n, input int pause_at, input bit mode_ok);
    int cnt;
    logic prev_sdo;
    cnt = 0;
    if (!mode_ok) par_wr_n = 1'b0;
    #(2*H);
    cs_n = 1'b0;
    #(2*H);
    for (int i = n - 1; i >= 0; i--) begin
      if (n - 1 - i == pause_at) #(10*H);
      prev_sdo = sdo;
      sdi = bits[i];
      #H sclk = 1'b1;
      if (mode_ok) begin stream.push_back(bits[i]); cnt++; end
      #H sclk = 1'b0;
      #H;
      if (mode_ok)
        check(sdo == sbit(stream.size() - 1 - 15), "R3 echo delay", {31'h0, sdo},
              {31'h0, sbit(stream.size() - 1 - 15)});
      else
        check(sdo == prev_sdo, "R5 gated frame no shift", {31'h0, sdo}, {31'h0, prev_sdo});
    end
    if (mode_ok && cnt >= 16) begin
      logic [15:0] wa, wb;
      int L;
      L = stream.size();
      for (int k = 0; k < 16; k++) begin
        wa[15-k] = sbit(L - 16 + k);
        wb[15-k] = sbit(L - 32 + k);
      end
      exp_a.push_back(wa);
      exp_b.push_back(wb);
    end
    #H cs_n = 1'b1;
    #(4*H);
    par_wr_n = 1'b1;
  endtask

  initial begin
    #(100*TCLK * 2000);
    check(0, "watchdog", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic held;
    #(20*TCLK) rst_n = 1'b1;
    #(20*TCLK);
    @(negedge clk);
    // R9 reset state
    check(sdo == 0 && load == 0, "R9 reset outputs", {30'h0, sdo, load}, 32'h0);
    check(word == 0 && {upd, addr, data} == 0, "R9 reset word", {16'h0, word}, 32'h0);

    send_frame(64'hA5C3, 16, -1, 1);          // R1 R8 plain word
    send_frame(64'h0049, 16, -1, 1);          // R8 update flag and disable bit
    send_frame(64'h0000_00F0_3E5A, 24, -1, 1); // R6 longer frame keeps last 16
    send_frame(64'h03FF, 10, -1, 1);          // R7 short frame dropped
    send_frame(64'h1234, 16, 8, 1);           // R1 two bytes with a pause
    send_frame(64'hFFFF, 16, -1, 0);          // R5 strobe low, ignored
    par_ce_n = 1'b0;
    send_frame(64'h0F0F, 16, -1, 0);          // R5 enable low (wr also low in task)
    par_ce_n = 1'b1;

    // R4: clock toggles while deselected
    held = sdo;
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      #H sclk = 1'b1;
      #H sclk = 1'b0;
    end
    #H;
    check(sdo == held, "R4 sdo held while deselected", {31'h0, sdo}, {31'h0, held});

    // R10: 32-clock frame through the cascade
    send_frame(64'hBEEF_6C21, 32, -1, 1);
    send_frame(64'h8001_7E42, 32, 16, 1);
    // R2: the next echoed bits confirm idle toggles were not captured
    send_frame(64'h5555, 16, -1, 1);

    #(20*H);
    check(exp_a.size() == 0, "R6 all loads seen", exp_a.size(), 0);
    check(exp_b.size() == 0, "R10 all tail loads seen", exp_b.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule